// File: doc/BRIEF.md
# Control-Flow Hash Monitor

This block runs beside a packet-processing core and follows it one retired instruction at a time. For each step the core reports a short hash of the instruction word. The block compares that hash against the expected value in a monitoring graph held in local storage. Each graph entry describes one instruction of the installed program. When the hashes agree, the monitor moves to that entry's successor. When the entry is a control-flow instruction, the monitor cannot tell which way the branch resolved, so it accepts either the fall-through successor or the branch target on the following step.

A disagreement is treated as evidence that the core is running code that was never installed. The monitor pulses an alarm, asserts a reset request towards the core and stops checking. It resumes at the program entry point once the core acknowledges the reset. The graph can be rewritten through a write port at any time, so a new program and its graph can be installed while the system is running. Each step reads at most two entries: the fall-through candidate and, after a branch, the target candidate.

Top module: `hash_flow_monitor`

## Requirements
- R1: After reset, `alarm_o` and `core_rst_o` are low and the next step is checked against graph entry 0.
- R2: A graph entry is written as {hash (4 bits), branch flag, next index, target index} through `wr_en_i`. The write is visible to any step presented from the following cycle onwards.
- R3: If a step's hash equals the hash of the current entry, no alarm is raised and the next step is checked against that entry's next index.
- R4: If a step's hash matches no candidate, `alarm_o` is high for exactly one cycle, starting in the cycle after the step. `core_rst_o` rises in the same cycle.
- R5: After a matched entry whose branch flag is set, the next step is accepted if it matches either the entry at the next index or the entry at the target index. Checking then continues from whichever entry matched.
- R6: When both branch candidates match, the fall-through (next index) candidate is followed.
- R7: A next or target index of all ones (63 with 6-bit indices) marks the end of the program, and that candidate becomes entry 0.
- R8: While `core_rst_o` is high, steps are ignored and raise no alarm. `core_rst_o` stays high until `core_rst_ack_i` is seen, and drops in the following cycle.
- R9: After the reset acknowledge, checking restarts at entry 0 with no branch pending.
- R10: Cycles with `step_valid_i` low raise no alarm and leave the checking position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid_i | input | 1 | Core reports one executed instruction this cycle |
| step_hash_i | input | 4 | Hash of the executed instruction |
| wr_en_i | input | 1 | Graph entry write strobe |
| wr_addr_i | input | 6 | Graph entry index to write |
| wr_hash_i | input | 4 | Expected hash for the entry |
| wr_branch_i | input | 1 | Entry is a control-flow instruction |
| wr_next_i | input | 6 | Fall-through successor index (all ones = end) |
| wr_target_i | input | 6 | Branch target index (all ones = end) |
| core_rst_ack_i | input | 1 | Core confirms it has been reset |
| alarm_o | output | 1 | One-cycle pulse on a hash mismatch |
| core_rst_o | output | 1 | Reset request to the core, held until acknowledged |

## Verification
The checker module watches the port protocol on every cycle: the alarm is a single-cycle pulse that only appears together with the reset request, the request is held until acknowledged and drops the cycle after, and idle or held cycles never produce an alarm. Which successor the monitor actually follows cannot be seen at the ports in a single cycle. Branch acceptance, the fall-through preference, the end-of-program wrap and the restart at entry 0 are shown only by the bench's step sequences, where a later step's hash exposes the entry that was selected. The bench also sweeps every stored hash against every reported hash.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
   typedef enum logic {
      WALK_RUN  = 1'b0,
      WALK_HOLD = 1'b1
   } walk_state_e;

   localparam int unsigned HASH_W_MAX = 8;
   localparam int unsigned IDX_W_MIN  = 2;
   localparam int unsigned IDX_W_MAX  = 10;
endpackage

// File: rtl/cfm_graph_mem.sv
module cfm_graph_mem #(
   parameter int unsigned HASH_W      = 4,
   parameter int unsigned IDX_W       = 6,
   parameter bit          CLEAR_ON_RST = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_addr,
   input  logic [HASH_W+2*IDX_W:0]       wr_data,
   input  logic [IDX_W-1:0]              rd_a_addr,
   input  logic [IDX_W-1:0]              rd_b_addr,
   output logic [HASH_W+2*IDX_W:0]       rd_a_data,
   output logic [HASH_W+2*IDX_W:0]       rd_b_data
);
   localparam int unsigned DEPTH = 1 << IDX_W;
   localparam int unsigned ENT_W = HASH_W + 2*IDX_W + 1;

   logic [ENT_W-1:0] store_q [DEPTH];

   generate
      if (CLEAR_ON_RST) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
            end else if (wr_en) begin
               store_q[wr_addr] <= wr_data;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (wr_en) store_q[wr_addr] <= wr_data;
         end
      end
   endgenerate

   assign rd_a_data = store_q[rd_a_addr];
   assign rd_b_data = store_q[rd_b_addr];
endmodule

// File: rtl/cfm_pick.sv
module cfm_pick #(
   parameter int unsigned HASH_W         = 4,
   parameter int unsigned IDX_W          = 6,
   parameter bit          FALLTHRU_FIRST = 1'b1
) (
   input  logic [HASH_W+2*IDX_W:0] ent_a,
   input  logic [HASH_W+2*IDX_W:0] ent_b,
   input  logic                    b_live,
   input  logic [HASH_W-1:0]       hash,
   output logic                    hit,
   output logic                    sel_branch,
   output logic [IDX_W-1:0]        sel_next,
   output logic [IDX_W-1:0]        sel_tgt
);
   localparam int unsigned ENT_W = HASH_W + 2*IDX_W + 1;
   localparam int unsigned BR_B  = 2*IDX_W;

   logic              match_a, match_b, use_b;
   logic [ENT_W-1:0]  chosen;

   assign match_a = (ent_a[ENT_W-1 -: HASH_W] == hash);
   assign match_b = b_live && (ent_b[ENT_W-1 -: HASH_W] == hash);
   assign hit     = match_a || match_b;

   generate
      if (FALLTHRU_FIRST) begin : g_fall_first
         assign use_b = match_b && !match_a;
      end else begin : g_tgt_first
         assign use_b = match_b;
      end
   endgenerate

   assign chosen     = use_b ? ent_b : ent_a;
   assign sel_branch = chosen[BR_B];
   assign sel_next   = chosen[2*IDX_W-1 -: IDX_W];
   assign sel_tgt    = chosen[IDX_W-1:0];
endmodule

// File: rtl/cfm_walker.sv
module cfm_walker
   import cfm_pkg::*;
#(
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_valid,
   input  logic             hit,
   input  logic             sel_branch,
   input  logic [IDX_W-1:0] sel_next,
   input  logic [IDX_W-1:0] sel_tgt,
   input  logic             rst_ack,
   output logic [IDX_W-1:0] cand_a,
   output logic [IDX_W-1:0] cand_b,
   output logic             b_live,
   output logic             alarm,
   output logic             core_rst
);
   walk_state_e state_q;

   function automatic logic [IDX_W-1:0] wrap_end(input logic [IDX_W-1:0] idx);
      return (&idx) ? '0 : idx;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WALK_RUN;
         cand_a  <= '0;
         cand_b  <= '0;
         b_live  <= 1'b0;
         alarm   <= 1'b0;
      end else begin
         alarm <= 1'b0;
         unique case (state_q)
            WALK_RUN: begin
               if (step_valid) begin
                  if (hit) begin
                     cand_a <= wrap_end(sel_next);
                     b_live <= sel_branch;
                     if (sel_branch) cand_b <= wrap_end(sel_tgt);
                  end else begin
                     alarm   <= 1'b1;
                     state_q <= WALK_HOLD;
                  end
               end
            end
            WALK_HOLD: begin
               if (rst_ack) begin
                  state_q <= WALK_RUN;
                  cand_a  <= '0;
                  b_live  <= 1'b0;
               end
            end
            default: state_q <= WALK_RUN;
         endcase
      end
   end

   assign core_rst = (state_q == WALK_HOLD);
endmodule

// File: rtl/hash_flow_monitor.sv
module hash_flow_monitor #(
   parameter int unsigned HASH_W         = 4,
   parameter int unsigned IDX_W          = 6,
   parameter bit          FALLTHRU_FIRST = 1'b1,
   parameter bit          CLEAR_ON_RST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_valid_i,
   input  logic [HASH_W-1:0] step_hash_i,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_addr_i,
   input  logic [HASH_W-1:0] wr_hash_i,
   input  logic              wr_branch_i,
   input  logic [IDX_W-1:0]  wr_next_i,
   input  logic [IDX_W-1:0]  wr_target_i,
   input  logic              core_rst_ack_i,
   output logic              alarm_o,
   output logic              core_rst_o
);
   localparam int unsigned ENT_W = HASH_W + 2*IDX_W + 1;

   generate
      if (HASH_W < 1 || HASH_W > cfm_pkg::HASH_W_MAX) begin : g_bad_hash
         $error("hash_flow_monitor: HASH_W out of range");
      end
      if (IDX_W < cfm_pkg::IDX_W_MIN || IDX_W > cfm_pkg::IDX_W_MAX) begin : g_bad_idx
         $error("hash_flow_monitor: IDX_W out of range");
      end
   endgenerate

   logic [ENT_W-1:0] wr_ent, ent_a, ent_b;
   logic [IDX_W-1:0] cand_a, cand_b, sel_next, sel_tgt;
   logic             b_live, hit, sel_branch;

   assign wr_ent = {wr_hash_i, wr_branch_i, wr_next_i, wr_target_i};

   cfm_graph_mem #(
      .HASH_W(HASH_W), .IDX_W(IDX_W), .CLEAR_ON_RST(CLEAR_ON_RST)
   ) graph_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_ent),
      .rd_a_addr(cand_a), .rd_b_addr(cand_b),
      .rd_a_data(ent_a), .rd_b_data(ent_b)
   );

   cfm_pick #(
      .HASH_W(HASH_W), .IDX_W(IDX_W), .FALLTHRU_FIRST(FALLTHRU_FIRST)
   ) pick_i (
      .ent_a(ent_a), .ent_b(ent_b), .b_live(b_live), .hash(step_hash_i),
      .hit(hit), .sel_branch(sel_branch), .sel_next(sel_next), .sel_tgt(sel_tgt)
   );

   cfm_walker #(.IDX_W(IDX_W)) walk_i (
      .clk(clk), .rst_n(rst_n), .step_valid(step_valid_i), .hit(hit),
      .sel_branch(sel_branch), .sel_next(sel_next), .sel_tgt(sel_tgt),
      .rst_ack(core_rst_ack_i),
      .cand_a(cand_a), .cand_b(cand_b), .b_live(b_live),
      .alarm(alarm_o), .core_rst(core_rst_o)
   );
endmodule

// File: rtl/cfm_checker.sv
module cfm_checker (
   input logic clk,
   input logic rst_n,
   input logic step_valid_i,
   input logic core_rst_ack_i,
   input logic alarm_o,
   input logic core_rst_o
);
   AST_ALARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_o |=> !alarm_o); // R4

   AST_ALARM_WITH_RST: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_o |-> core_rst_o); // R4

   AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rst_o && !core_rst_ack_i) |=> core_rst_o); // R8

   AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rst_o && core_rst_ack_i) |=> !core_rst_o); // R8

   AST_HOLD_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_o |=> !alarm_o); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !step_valid_i |=> !alarm_o); // R10
endmodule

bind hash_flow_monitor cfm_checker chk_i (
   .clk(clk), .rst_n(rst_n), .step_valid_i(step_valid_i),
   .core_rst_ack_i(core_rst_ack_i), .alarm_o(alarm_o), .core_rst_o(core_rst_o)
);

// File: tb/hash_flow_monitor_tb_top.sv
`timescale 1ns/1ps
module hash_flow_monitor_tb_top;
   localparam int HW = 4;
   localparam int IW = 6;
   localparam logic [IW-1:0] END_IDX = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic step_valid_i = 1'b0;
   logic [HW-1:0] step_hash_i = '0;
   logic wr_en_i = 1'b0;
   logic [IW-1:0] wr_addr_i = '0;
   logic [HW-1:0] wr_hash_i = '0;
   logic wr_branch_i = 1'b0;
   logic [IW-1:0] wr_next_i = '0;
   logic [IW-1:0] wr_target_i = '0;
   logic core_rst_ack_i = 1'b0;
   logic alarm_o, core_rst_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   hash_flow_monitor dut_i (
      .clk(clk), .rst_n(rst_n), .step_valid_i(step_valid_i), .step_hash_i(step_hash_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_hash_i(wr_hash_i),
      .wr_branch_i(wr_branch_i), .wr_next_i(wr_next_i), .wr_target_i(wr_target_i),
      .core_rst_ack_i(core_rst_ack_i), .alarm_o(alarm_o), .core_rst_o(core_rst_o)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic put(input int a, input int h, input bit br, input int nx, input int tg);
      @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = IW'(a); wr_hash_i = HW'(h);
      wr_branch_i = br; wr_next_i = IW'(nx); wr_target_i = IW'(tg);
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   // present one step; on return alarm_o/core_rst_o reflect it
   task automatic step(input int h);
      @(negedge clk);
      step_valid_i = 1'b1; step_hash_i = HW'(h);
      @(negedge clk);
      step_valid_i = 1'b0;
   endtask

   task automatic expect_step(input string req, input int h, input bit exp_alarm);
      step(h);
      check(req, "alarm", alarm_o, exp_alarm);
      check(req, "core_rst", core_rst_o, exp_alarm);
      if (alarm_o) begin
         @(negedge clk);
         check("R4", "alarm width", alarm_o, 1'b0);
      end
   endtask

   task automatic ack();
      @(negedge clk);
      core_rst_ack_i = 1'b1;
      @(negedge clk);
      core_rst_ack_i = 1'b0;
      check("R8", "release after ack", core_rst_o, 1'b0);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet outputs after reset
      check("R1", "alarm after reset", alarm_o, 1'b0);
      check("R1", "core_rst after reset", core_rst_o, 1'b0);
      // R1: cleared graph, entry 0 hash 0, next 0 -> hash 0 accepted
      expect_step("R1", 0, 1'b0);

      // R2 R3 R4 R7: sweep stored hash vs reported hash on an end-marked entry 0
      for (int s = 0; s < 16; s++) begin
         put(0, s, 1'b0, END_IDX, 0);
         for (int x = 0; x < 16; x++) begin
            expect_step((x == s) ? "R3" : "R4", x, (x != s));
            if (x != s) ack();
         end
      end

      // R3 R10: linear walk 0(5)->1(9)->2(12)->end, with idle gaps
      put(0, 5, 1'b0, 1, 0);
      put(1, 9, 1'b0, 2, 0);
      put(2, 12, 1'b0, END_IDX, 0);
      expect_step("R3", 5, 1'b0);
      repeat (7) @(negedge clk);
      check("R10", "idle alarm", alarm_o, 1'b0);
      expect_step("R10", 9, 1'b0);
      expect_step("R3", 12, 1'b0);
      expect_step("R7", 5, 1'b0);
      expect_step("R3", 5, 1'b1);   // entry 1 expects 9
      ack();

      // R8 R9: mismatch, steps ignored while held, restart at 0
      expect_step("R4", 6, 1'b1);
      for (int k = 0; k < 16; k++) begin
         step(k);
         check("R8", "no alarm while held", alarm_o, 1'b0);
         check("R8", "held", core_rst_o, 1'b1);
      end
      ack();
      expect_step("R9", 5, 1'b0);
      expect_step("R9", 9, 1'b0);
      expect_step("R9", 12, 1'b0);

      // R5: entry 0 branch, next 1 (7, ->2 hash 2), target 5 (9, end)
      put(0, 3, 1'b1, 1, 5);
      put(1, 7, 1'b0, 2, 0);
      put(2, 2, 1'b0, END_IDX, 0);
      put(5, 9, 1'b0, END_IDX, 0);
      expect_step("R5", 3, 1'b0);
      expect_step("R5", 7, 1'b0);
      expect_step("R5", 2, 1'b0);
      expect_step("R5", 3, 1'b0);
      expect_step("R5", 9, 1'b0);
      expect_step("R7", 3, 1'b0);
      expect_step("R5", 1, 1'b1);
      ack();

      // R6: both candidates hash 7; fall-through leads to 2 (hash 2), target to 6 (hash 4)
      put(5, 7, 1'b0, 6, 0);
      put(6, 4, 1'b0, END_IDX, 0);
      expect_step("R6", 3, 1'b0);
      expect_step("R6", 7, 1'b0);
      expect_step("R6", 4, 1'b1);
      ack();
      expect_step("R6", 3, 1'b0);
      expect_step("R6", 7, 1'b0);
      expect_step("R6", 2, 1'b0);

      // R7: branch target of all ones wraps to entry 0
      put(0, 3, 1'b1, 1, END_IDX);
      expect_step("R7", 3, 1'b0);
      expect_step("R7", 3, 1'b0);
      expect_step("R7", 7, 1'b0);
      expect_step("R7", 2, 1'b0);

      // R2: rewrite entry 0 at runtime; old hash now rejected, new accepted
      put(0, 11, 1'b0, END_IDX, 0);
      expect_step("R2", 3, 1'b1);
      ack();
      expect_step("R2", 11, 1'b0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule